// File: doc/BRIEF.md
# Request-Triggered Frame Transfer Engine

This block copies 32-bit words from a window of peripheral registers into system RAM, one frame per incoming request. A packet held in the block gives the first source address, the first destination address, the number of frames and the number of words per frame. Each request from the capturing peripheral runs one frame: the engine reads a word from the peripheral side, writes it to RAM, and repeats until the frame's element count runs out. The reads and writes go through a single memory port with a ready handshake.

Inside a frame the source address climbs by a fixed stride, 16 bytes by default. It jumps back to its first value at the start of every frame, so each frame samples the same set of peripheral fields. The destination address moves on by 4 bytes after every word and is never reset between frames, so the frames land one after another in a single buffer. A frame counter ends the job. When the last frame finishes, a one-cycle done pulse fires and a sticky complete flag rises. Loading a new packet, or pulsing restart, puts every counter and address back to its starting value.

A request that arrives while a frame is running is held in a single pending flag and is served as soon as that frame ends. Any further request that comes while the flag is already set is lost and counted as an overrun.

Top module: `frame_dma_seq`

## Requirements
- R1: After reset the block is idle: mem_req, busy, done, complete and pend are 0, and overrun_cnt, frame_left and elem_left are 0.
- R2: trig is ignored when no packet has been loaded since reset, and also while complete is 1. No memory access follows it.
- R3: A frame is made of elem_count read/write pairs. A read (mem_we=0) is always followed by a write (mem_we=1) of the same element. A request holds its address and direction until mem_ready is seen, and the next read starts only after the write is accepted.
- R4: For element e (0-based) of every frame, the read address is src_base + 16*e. The source address returns to src_base at the start of each frame.
- R5: The write address of word k (0-based, counted over the whole job in frame-major, element-minor order) is dst_base + 4*k. With src 0x38, dst 0x70, 3 frames and 3 elements, the ninth word is written to 0x90.
- R6: The data written for each element equals the 32-bit mem_rdata accepted by the read of that element.
- R7: elem_left reads elem_count - e during the read of element e. frame_left starts at frame_count and drops by one at the end of each frame, reaching 0 after the last frame.
- R8: When the last frame ends, done is 1 for exactly one cycle, and complete rises and stays 1. Exactly frame_count*elem_count words are written.
- R9: A trig while a frame runs sets pend, and the pending frame starts right after the current one ends. A trig while pend is already 1 increments overrun_cnt, which saturates at its maximum.
- R10: A pulse on cfg_load or restart aborts any transfer and clears done, complete, pend and overrun_cnt. It sets frame_left and elem_left to the packet counts, and the next frame starts from the packet's base addresses.
- R11: The low two bits of cfg_src_addr and cfg_dst_addr are ignored: the bases used are the given values with bits [1:0] forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the packet fields and restore the counters |
| cfg_src_addr | input | AW | Source base byte address |
| cfg_dst_addr | input | AW | Destination base byte address |
| cfg_frames | input | FW | Number of frames (at least 1) |
| cfg_elems | input | EW | Words per frame (at least 1) |
| restart | input | 1 | Restore counters and addresses from the held packet |
| trig | input | 1 | Frame request, one cycle per request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write to RAM, 0 for a read from the peripheral |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken when mem_ready is 1 |
| mem_ready | input | 1 | Access accepted this cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of the job |
| complete | output | 1 | Sticky end-of-job flag |
| pend | output | 1 | A request is waiting to be served |
| overrun_cnt | output | OW | Requests lost while one was already pending |
| frame_left | output | FW | Frames still to run |
| elem_left | output | EW | Elements left in the current frame |

## Verification
The hardest state to reach is a burst of requests during a stalled frame. The pending flag has to be set and overruns counted, then the held request must start the next frame without any gap. The bench stretches each memory access with a programmable number of not-ready cycles. This widens a frame enough to fire several one-cycle requests into it. The vector table also mixes two trigger patterns: one request per idle period, and requests fired while a frame is still running. A restart in the middle of a frame is driven as a directed case, and the bench checks that the aborted frame leaves no trace in the addresses used afterwards.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } fdma_st_e;
endpackage

// File: rtl/fdma_trig_gate.sv
// Request intake: direct start, one pending slot, saturating overrun count.
module fdma_trig_gate #(
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          drop,
  input  logic          trig,
  input  logic          armed,
  input  logic          idle,
  output logic          frame_go,
  output logic          pend_q,
  output logic [OW-1:0] ovr_q
);
  localparam logic [OW-1:0] OVR_MAX = {OW{1'b1}};

  logic          take_direct;
  logic          spare;
  logic          consume;
  logic          pend_d;
  logic [OW-1:0] ovr_d;

  always_comb begin
    take_direct = idle & armed & ~pend_q & trig;
    frame_go    = idle & armed & (pend_q | trig);
    consume     = frame_go & pend_q;
    spare       = trig & armed & ~take_direct;

    if (clr_all || drop || !armed) begin
      pend_d = 1'b0;
    end else begin
      pend_d = (pend_q & ~consume) | spare;
    end

    ovr_d = ovr_q;
    if (clr_all) begin
      ovr_d = '0;
    end else if (spare && pend_q && !consume && (ovr_q != OVR_MAX)) begin
      ovr_d = ovr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end
endmodule

// File: rtl/fdma_ctrl.sv
// Frame sequencer: read/write pairs, element and frame counters, end flags.
module fdma_ctrl
  import fdma_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          frame_go,
  input  logic          mem_ready,
  input  logic [EW-1:0] elems_use,
  input  logic [FW-1:0] frames_use,
  output fdma_st_e      st_q,
  output logic          go,
  output logic          rd_acc,
  output logic          wr_acc,
  output logic          fin,
  output logic [EW-1:0] elem_q,
  output logic [FW-1:0] frame_q,
  output logic          done_q,
  output logic          complete_q
);
  localparam logic [EW-1:0] ELEM_ONE  = EW'(1);
  localparam logic [FW-1:0] FRAME_ONE = FW'(1);

  fdma_st_e      st_d;
  logic          last_elem;
  logic          frame_end;
  logic [EW-1:0] elem_d;
  logic [FW-1:0] frame_d;
  logic          complete_d;

  always_comb begin
    go        = frame_go & (st_q == ST_IDLE) & ~restore;
    rd_acc    = (st_q == ST_RD) & mem_ready & ~restore;
    wr_acc    = (st_q == ST_WR) & mem_ready & ~restore;
    last_elem = (elem_q == ELEM_ONE);
    frame_end = wr_acc & last_elem;
    fin       = frame_end & (frame_q == FRAME_ONE);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go)     st_d = ST_RD;
      ST_RD:   if (rd_acc) st_d = ST_WR;
      ST_WR:   if (wr_acc) st_d = last_elem ? ST_IDLE : ST_RD;
      default:             st_d = ST_IDLE;
    endcase
    if (restore) st_d = ST_IDLE;
  end

  always_comb begin
    elem_d = elem_q;
    if (restore || go) begin
      elem_d = elems_use;
    end else if (wr_acc) begin
      elem_d = last_elem ? elems_use : elem_q - 1'b1;
    end

    frame_d = frame_q;
    if (restore) begin
      frame_d = frames_use;
    end else if (frame_end) begin
      frame_d = frame_q - 1'b1;
    end

    complete_d = complete_q;
    if (restore) begin
      complete_d = 1'b0;
    end else if (fin) begin
      complete_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      elem_q     <= '0;
      frame_q    <= '0;
      complete_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      elem_q     <= elem_d;
      frame_q    <= frame_d;
      complete_q <= complete_d;
      done_q     <= fin;
    end
  end
endmodule

// File: rtl/fdma_addr_gen.sv
// Address pair: source rewinds per frame, destination runs across frames.
module fdma_addr_gen #(
  parameter int AW         = 16,
  parameter int SRC_STRIDE = 16,
  parameter int DST_STEP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          go,
  input  logic          wr_acc,
  input  logic [AW-1:0] src_use,
  input  logic [AW-1:0] dst_use,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q
);
  localparam logic [AW-1:0] SRC_INC = AW'(SRC_STRIDE);
  localparam logic [AW-1:0] DST_INC = AW'(DST_STEP);

  logic [AW-1:0] src_d;
  logic [AW-1:0] dst_d;

  always_comb begin
    src_d = src_q;
    if (restore || go) begin
      src_d = src_use;
    end else if (wr_acc) begin
      src_d = src_q + SRC_INC;
    end

    dst_d = dst_q;
    if (restore) begin
      dst_d = dst_use;
    end else if (wr_acc) begin
      dst_d = dst_q + DST_INC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end
endmodule

// File: rtl/frame_dma_seq.sv
module frame_dma_seq
  import fdma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int FW         = 8,
  parameter int EW         = 8,
  parameter int OW         = 4,
  parameter int SRC_STRIDE = 16,
  parameter int DST_STEP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [FW-1:0] cfg_frames,
  input  logic [EW-1:0] cfg_elems,
  input  logic          restart,
  input  logic          trig,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          complete,
  output logic          pend,
  output logic [OW-1:0] overrun_cnt,
  output logic [FW-1:0] frame_left,
  output logic [EW-1:0] elem_left
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

  // packet registers
  logic [AW-1:0] src_base_q, dst_base_q;
  logic [FW-1:0] frames_q;
  logic [EW-1:0] elems_q;
  logic          loaded_q;

  logic [AW-1:0] src_use, dst_use;
  logic [FW-1:0] frames_use;
  logic [EW-1:0] elems_use;
  logic          restore;
  logic          armed;
  logic          idle;

  fdma_st_e      st_q;
  logic          go, rd_acc, wr_acc, fin;
  logic          frame_go;
  logic          done_q, complete_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] data_q;

  always_comb begin
    restore    = cfg_load | restart;
    src_use    = cfg_load ? (cfg_src_addr & WORD_MASK) : src_base_q;
    dst_use    = cfg_load ? (cfg_dst_addr & WORD_MASK) : dst_base_q;
    frames_use = cfg_load ? cfg_frames : frames_q;
    elems_use  = cfg_load ? cfg_elems  : elems_q;
    armed      = loaded_q & ~complete_q;
    idle       = (st_q == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base_q <= '0;
      dst_base_q <= '0;
      frames_q   <= '0;
      elems_q    <= '0;
      loaded_q   <= 1'b0;
    end else if (cfg_load) begin
      src_base_q <= src_use;
      dst_base_q <= dst_use;
      frames_q   <= cfg_frames;
      elems_q    <= cfg_elems;
      loaded_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_acc) begin
      data_q <= mem_rdata;
    end
  end

  fdma_trig_gate #(.OW(OW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (restore),
    .drop     (fin),
    .trig     (trig),
    .armed    (armed),
    .idle     (idle),
    .frame_go (frame_go),
    .pend_q   (pend),
    .ovr_q    (overrun_cnt)
  );

  fdma_ctrl #(.EW(EW), .FW(FW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .restore    (restore),
    .frame_go   (frame_go),
    .mem_ready  (mem_ready),
    .elems_use  (elems_use),
    .frames_use (frames_use),
    .st_q       (st_q),
    .go         (go),
    .rd_acc     (rd_acc),
    .wr_acc     (wr_acc),
    .fin        (fin),
    .elem_q     (elem_left),
    .frame_q    (frame_left),
    .done_q     (done_q),
    .complete_q (complete_q)
  );

  fdma_addr_gen #(.AW(AW), .SRC_STRIDE(SRC_STRIDE), .DST_STEP(DST_STEP)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restore (restore),
    .go      (go),
    .wr_acc  (wr_acc),
    .src_use (src_use),
    .dst_use (dst_use),
    .src_q   (src_q),
    .dst_q   (dst_q)
  );

  always_comb begin
    mem_req   = (st_q != ST_IDLE);
    mem_we    = (st_q == ST_WR);
    mem_addr  = mem_we ? dst_q : src_q;
    mem_wdata = data_q;
    busy      = mem_req;
    done      = done_q;
    complete  = complete_q;
  end
endmodule

// File: rtl/frame_dma_seq_chk.sv
module frame_dma_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          restart,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          complete,
  input logic          pend
);
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && !restart && !cfg_load) |=> (mem_req && mem_we));

  a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !restart && !cfg_load)
      |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_quiet_when_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> (!mem_req && !busy));

  a_r9_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !busy && !restart && !cfg_load) |=> busy);

  a_r10_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || cfg_load) |=> (!busy && !complete && !pend && !done));

  a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind frame_dma_seq frame_dma_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .restart   (restart),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .complete  (complete),
  .pend      (pend)
);

// File: tb/frame_dma_seq_tb_top.sv
`timescale 1ns/1ps
module frame_dma_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int FW = 8;
  localparam int EW = 8;
  localparam int OW = 4;
  localparam int WD_LIMIT = 20000;
  localparam int NV = 5;
  // {src[63:48], dst[47:32], frames[31:24], elems[23:16], mode[15:8], stall[7:0]}
  // mode 0: one request per idle period; mode 1: requests fired while busy
  localparam logic [63:0] VEC [NV] = '{
    64'h0038_0070_03_03_00_00,
    64'h0100_0400_02_04_01_02,
    64'h003B_0073_02_02_00_01,
    64'h0200_0800_01_01_01_00,
    64'h0010_0A00_04_01_01_03
  };

  logic          clk, rst_n;
  logic          cfg_load, restart, trig;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
  logic [FW-1:0] cfg_frames;
  logic [EW-1:0] cfg_elems;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          busy, done, complete, pend;
  logic [OW-1:0] overrun_cnt;
  logic [FW-1:0] frame_left;
  logic [EW-1:0] elem_left;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_cyc = 0;
  int wait_cnt = 0;
  int ev_n = 0;
  int done_n = 0;
  logic          ev_we   [512];
  logic [AW-1:0] ev_addr [512];
  logic [DW-1:0] ev_data [512];
  logic [EW-1:0] ev_elem [512];

  frame_dma_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_frames(cfg_frames), .cfg_elems(cfg_elems),
    .restart(restart), .trig(trig),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .complete(complete), .pend(pend),
    .overrun_cnt(overrun_cnt), .frame_left(frame_left), .elem_left(elem_left)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  // memory model: ready after stall_cyc idle negedges, dropped after each accept
  always @(negedge clk) begin
    if (!mem_req || mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 0;
    end else if (wait_cnt >= stall_cyc) begin
      mem_ready <= 1'b1;
      mem_rdata <= rd_val(mem_addr);
    end else begin
      wait_cnt <= wait_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready && !restart && !cfg_load) begin
      ev_we[ev_n % 512]   <= mem_we;
      ev_addr[ev_n % 512] <= mem_addr;
      ev_data[ev_n % 512] <= mem_wdata;
      ev_elem[ev_n % 512] <= elem_left;
      ev_n <= ev_n + 1;
    end
    if (rst_n && done) done_n <= done_n + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      $display("FAIL R8 watchdog expired act=%0d exp<%0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic load_pkt(input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input logic [FW-1:0] f, input logic [EW-1:0] e);
    @(negedge clk);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_frames = f; cfg_elems = e;
    cfg_load = 1'b1;
    @(negedge clk) cfg_load = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int base, dbase;
    rst_n = 1'b0; cfg_load = 1'b0; restart = 1'b0; trig = 1'b0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_frames = '0; cfg_elems = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!mem_req && !busy && !done && !complete && !pend, "R1 idle flags",
        {mem_req, busy, done, complete, pend}, 0);
    chk(overrun_cnt == 0 && frame_left == 0 && elem_left == 0, "R1 counters",
        {overrun_cnt, frame_left, elem_left}, 0);

    // R2: request before any packet is loaded
    pulse_trig();
    repeat (5) @(negedge clk);
    chk(ev_n == 0 && !busy, "R2 trig without packet", ev_n, 0);

    // vector table
    for (int c = 0; c < NV; c++) begin
      logic [AW-1:0] vs, vd;
      logic [FW-1:0] vf;
      logic [EW-1:0] ve;
      logic [7:0]    vm;
      logic [AW-1:0] sb, db;
      vs = VEC[c][63:48]; vd = VEC[c][47:32]; vf = VEC[c][31:24];
      ve = VEC[c][23:16]; vm = VEC[c][15:8];  stall_cyc = int'(VEC[c][7:0]);
      sb = vs & 16'hFFFC; db = vd & 16'hFFFC;
      load_pkt(vs, vd, vf, ve);
      base = ev_n; dbase = done_n;
      chk(frame_left == vf && elem_left == ve && !complete, "R10 load restores",
          {frame_left, elem_left}, {vf, ve});
      if (vm == 0) begin
        for (int f = 0; f < int'(vf); f++) begin
          pulse_trig();
          wait_idle();
          chk(frame_left == vf - FW'(f + 1), "R7 frame_left after frame",
              frame_left, vf - FW'(f + 1));
        end
      end else begin
        pulse_trig();
        for (int f = 1; f < int'(vf); f++) begin
          while (pend) @(negedge clk);
          pulse_trig();
        end
      end
      while (!complete) @(negedge clk);
      @(negedge clk);
      chk(ev_n - base == 2 * int'(vf) * int'(ve), "R8 word count",
          ev_n - base, 2 * int'(vf) * int'(ve));
      chk(done_n - dbase == 1, "R8 single done pulse", done_n - dbase, 1);
      chk(complete && !busy && frame_left == 0, "R8 complete sticky",
          {complete, busy, frame_left}, {1'b1, 1'b0, 8'h00});
      for (int k = 0; k < int'(vf) * int'(ve); k++) begin
        int e;
        logic [AW-1:0] xs, xd;
        e  = k % int'(ve);
        xs = sb + AW'(16 * e);
        xd = db + AW'(4 * k);
        chk(!ev_we[(base + 2*k) % 512] && ev_we[(base + 2*k + 1) % 512],
            "R3 read then write", {ev_we[(base + 2*k) % 512], ev_we[(base + 2*k + 1) % 512]}, 2'b01);
        chk(ev_addr[(base + 2*k) % 512] == xs, "R4 R11 source address",
            ev_addr[(base + 2*k) % 512], xs);
        chk(ev_addr[(base + 2*k + 1) % 512] == xd, "R5 R11 destination address",
            ev_addr[(base + 2*k + 1) % 512], xd);
        chk(ev_data[(base + 2*k + 1) % 512] == rd_val(xs), "R6 data copied",
            ev_data[(base + 2*k + 1) % 512], rd_val(xs));
        chk(ev_elem[(base + 2*k) % 512] == ve - EW'(e), "R7 elem_left",
            ev_elem[(base + 2*k) % 512], ve - EW'(e));
      end
      if (c == 0) begin
        chk(ev_addr[(base + 17) % 512] == 16'h0090, "R5 ninth word at 0x90",
            ev_addr[(base + 17) % 512], 16'h0090);
        // R2: request after complete is ignored
        base = ev_n;
        pulse_trig();
        repeat (6) @(negedge clk);
        chk(ev_n == base && complete && !pend, "R2 trig after complete", ev_n - base, 0);
      end
    end

    // R9 pending and overrun under a stalled frame
    stall_cyc = 4;
    load_pkt(16'h0020, 16'h0100, 8'd2, 8'd2);
    base = ev_n;
    pulse_trig();
    pulse_trig();
    pulse_trig();
    pulse_trig();
    chk(pend && busy, "R9 pending set", {pend, busy}, 2'b11);
    chk(overrun_cnt == 2, "R9 overrun count", overrun_cnt, 2);
    while (!complete) @(negedge clk);
    @(negedge clk);
    chk(ev_n - base == 8, "R9 pending frame served", ev_n - base, 8);
    chk(ev_addr[(base + 7) % 512] == 16'h010C, "R9 R5 last write address",
        ev_addr[(base + 7) % 512], 16'h010C);
    pulse_restart();
    chk(!complete && overrun_cnt == 0 && frame_left == 2 && elem_left == 2,
        "R10 restart clears", {complete, overrun_cnt, frame_left, elem_left}, {1'b0, 4'h0, 8'd2, 8'd2});

    // R10 restart in the middle of a frame
    stall_cyc = 2;
    load_pkt(16'h0040, 16'h0300, 8'd2, 8'd3);
    pulse_trig();
    repeat (7) @(negedge clk);
    chk(busy && elem_left != 3, "R10 mid-frame progress", elem_left, 2);
    pulse_restart();
    chk(!busy && !mem_req && frame_left == 2 && elem_left == 3, "R10 abort restores",
        {busy, mem_req, frame_left, elem_left}, {1'b0, 1'b0, 8'd2, 8'd3});
    base = ev_n;
    pulse_trig();
    wait_idle();
    chk(ev_addr[base % 512] == 16'h0040 && ev_addr[(base + 1) % 512] == 16'h0300,
        "R10 bases after restart", {ev_addr[base % 512], ev_addr[(base + 1) % 512]},
        {16'h0040, 16'h0300});
    chk(frame_left == 1 && !complete, "R7 one frame left", frame_left, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule